// File: doc/BRIEF.md
# ADC Scan Sequencer with Dual-Unit Packing

This block drives two ADC converter units from a pair of programmable rule tables. Each trigger strobe starts one measurement event. The block takes the next rule from the table of each unit it serves and issues a conversion request that carries the channel, the attenuation and the resolution. It then waits for the results, which arrive with their own valid strobes.

Each returned result is packed into a 16-bit word and offered on a valid/ready stream toward a DMA engine. The unit mode sets which units serve a trigger: unit A only, unit B only, both at once, or the two in turn. The mode also sets the layout of the output word. Two running counters track the triggers and the words scheduled, and the DMA side uses them for its frame accounting.

Software sets up the block through a simple write port. The port loads the table words, the table lengths and the unit mode.

Top module: `adc_scan_seq`

## Requirements
- R1: Table words are written at `cfg_addr` 0..3 (unit A) and 4..7 (unit B). Word w holds entry 4w in bits [31:24], entry 4w+1 in [23:16], entry 4w+2 in [15:8] and entry 4w+3 in [7:0].
- R2: A rule byte holds attenuation in [1:0], resolution code in [3:2] and channel in [7:4]. A request shows these fields of the rule on `req_atten`, `req_res` and `req_chan`, in the slice of the unit that serves it (unit A low, unit B high).
- R3: `cfg_addr` 8 (unit A) and 9 (unit B) take a length minus one in `cfg_wdata[3:0]`. After reset the length is 1. Rules are used in index order, one per conversion, and the index wraps to 0 after the last used entry.
- R4: `cfg_addr` 10 sets the mode in `cfg_wdata[1:0]`: 0 means unit A only, 1 unit B only, 2 both units, 3 alternating. An accepted trigger raises `req_valid` for exactly the units served.
- R5: In alternating mode the first trigger serves unit A, and each later trigger serves the other unit. Any configuration write restarts the alternation at unit A.
- R6: In modes 0 and 1 an output word is {channel[3:0], data[11:0]}.
- R7: In modes 2 and 3 an output word is {unit, channel[3:0], data[10:0]}, with unit 0 for A and 1 for B. A 12-bit result drops its least significant bit to fit.
- R8: Resolution codes 0..3 keep 9, 10, 11 or 12 result bits. The kept bits are right-aligned, and the field bits above them are zero.
- R9: In both-unit mode a trigger yields two words, unit A first, whichever unit returns its result first.
- R10: `conv_cnt` rises by 1 per accepted trigger. `eof_cnt` rises by 2 per accepted trigger in both-unit mode and by 1 in the other modes. Both counters reset to 0.
- R11: A trigger that arrives while requests or words are still pending is ignored. A result strobe from a unit with no request pending is ignored.
- R12: Writing a unit's length or table resets its scan index to 0. If such a write falls in the cycle of an accepted trigger, that trigger uses the old rule and the index still ends at 0.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| trig | input | 1 | Measurement trigger strobe |
| req_valid | output | 2 | Conversion request per unit, held until the result arrives |
| req_chan | output | 8 | Channel per unit, 4 bits each |
| req_atten | output | 4 | Attenuation per unit, 2 bits each |
| req_res | output | 4 | Resolution code per unit, 2 bits each |
| res_valid | input | 2 | Result strobe per unit |
| res_data | input | 24 | Raw result per unit, 12 bits each |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | 16 | Packed output word |
| conv_cnt | output | 16 | Accepted trigger count |
| eof_cnt | output | 16 | Scheduled word count |

## Verification
A configuration write and an accepted trigger can land in the same cycle. The bench provokes this by raising a length write in the trigger cycle, once the scan index has moved past entry 0. It then checks that the request shows the old rule and that the next trigger starts again at entry 0. Result capture and a stalled output can also meet. In both-unit mode the bench returns unit B's result before unit A's and holds `out_ready` low. It then judges the word order and checks that the words stay stable while the stream is stalled.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NENT = 16,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          trig,
  output logic [1:0]    req_valid,
  output logic [7:0]    req_chan,
  output logic [3:0]    req_atten,
  output logic [3:0]    req_res,
  input  logic [1:0]    res_valid,
  input  logic [23:0]   res_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  output logic [CW-1:0] conv_cnt,
  output logic [CW-1:0] eof_cnt
);
  localparam int IW = $clog2(NENT);

  logic [7:0]    tab [2][NENT];
  logic [IW-1:0] idx [2];
  logic [IW-1:0] lenm1 [2];
  logic [7:0]    rl [2];
  logic [15:0]   word [2];
  logic [1:0]    mode, srv, req, full;
  logic          alt, dual_r, busy, acc, sel, pop;

  function automatic logic [15:0] pack(input logic u, input logic [7:0] r,
                                       input logic dual, input logic [11:0] d);
    logic [11:0] m;
    m = d & ~(12'hFFF << (9 + r[3:2]));
    if (dual) pack = {u, r[7:4], (r[3:2] == 2'd3) ? m[11:1] : m[10:0]};
    else      pack = {r[7:4], m};
  endfunction

  assign busy = |req | |full;
  assign acc  = trig & ~busy;
  assign sel  = ~full[0];
  assign out_valid = full[0] | (full[1] & ~req[0]);
  assign out_data  = word[sel];
  assign pop  = out_valid & out_ready;

  always_comb
    case (mode)
      2'd0:    srv = 2'b01;
      2'd1:    srv = 2'b10;
      2'd2:    srv = 2'b11;
      default: srv = alt ? 2'b10 : 2'b01;
    endcase

  assign req_valid = req;
  assign req_chan  = {rl[1][7:4], rl[0][7:4]};
  assign req_res   = {rl[1][3:2], rl[0][3:2]};
  assign req_atten = {rl[1][1:0], rl[0][1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; alt <= 1'b0; dual_r <= 1'b0;
      req <= '0; full <= '0;
      conv_cnt <= '0; eof_cnt <= '0;
      for (int u = 0; u < 2; u++) begin
        idx[u] <= '0; lenm1[u] <= '0; rl[u] <= '0; word[u] <= '0;
        for (int e = 0; e < NENT; e++) tab[u][e] <= '0;
      end
    end else begin
      if (acc) begin
        conv_cnt <= conv_cnt + 1'b1;
        eof_cnt  <= eof_cnt + ((mode == 2'd2) ? CW'(2) : CW'(1));
        dual_r   <= mode[1];
        if (mode == 2'd3) alt <= ~alt;
      end
      if (pop) full[sel] <= 1'b0;
      for (int u = 0; u < 2; u++) begin
        if (acc && srv[u]) begin
          req[u] <= 1'b1;
          rl[u]  <= tab[u][idx[u]];
          idx[u] <= (idx[u] == lenm1[u]) ? '0 : idx[u] + 1'b1;
        end
        if (req[u] && res_valid[u]) begin
          req[u]  <= 1'b0;
          full[u] <= 1'b1;
          word[u] <= pack(u[0], rl[u], dual_r, res_data[12*u +: 12]);
        end
        if (cfg_we && !cfg_addr[3] && cfg_addr[2] == u[0]) begin
          for (int k = 0; k < 4; k++)
            if (4 * int'(cfg_addr[1:0]) + k < NENT)
              tab[u][4 * int'(cfg_addr[1:0]) + k] <= cfg_wdata[31 - 8*k -: 8];
          idx[u] <= '0;
          alt    <= 1'b0;
        end
        if (cfg_we && cfg_addr == 4'd8 + 4'(u)) begin
          lenm1[u] <= cfg_wdata[IW-1:0];
          idx[u]   <= '0;
          alt      <= 1'b0;
        end
      end
      if (cfg_we && cfg_addr == 4'd10) begin
        mode <= cfg_wdata[1:0];
        alt  <= 1'b0;
      end
    end
  end

  a_r13_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r10_conv_step: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !busy |=> conv_cnt == $past(conv_cnt) + 1'b1);

  a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy |=> $stable(conv_cnt) && $stable(eof_cnt));

  a_r4_req_from_trig_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid[0]) |-> $past(trig));

  a_r4_req_from_trig_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid[1]) |-> $past(trig));

  a_r9_both_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid[0]) && $past(mode) == 2'd2 |-> $rose(req_valid[1]));
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int PER = 10;
  logic clk = 0, rst_n = 0, cfg_we = 0, trig = 0, out_ready = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [1:0] res_valid = 0;
  logic [23:0] res_data = 0;
  logic [1:0] req_valid;
  logic [7:0] req_chan;
  logic [3:0] req_atten, req_res;
  logic out_valid;
  logic [15:0] out_data, conv_cnt, eof_cnt;

  adc_scan_seq i_adc_scan_seq (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig(trig), .req_valid(req_valid), .req_chan(req_chan),
    .req_atten(req_atten), .req_res(req_res), .res_valid(res_valid), .res_data(res_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .conv_cnt(conv_cnt), .eof_cnt(eof_cnt));

  always #(PER/2) clk = ~clk;

  int vectors = 0, fails = 0, nvec = 0;
  int idx [2], len [2];
  int mode_m = 0, alt_m = 0, conv_m = 0, eof_m = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int rule(input int u, input int e);
    return (((e ^ (u * 5)) & 15) << 4) | ((e % 4) << 2) | ((e + u) % 4);
  endfunction

  function automatic int expw(input int u, input int r, input bit dual, input int d);
    int bits, m, ch;
    bits = 9 + ((r >> 2) & 3);
    m = d & ((1 << bits) - 1);
    ch = (r >> 4) & 15;
    if (dual) return (u << 15) | (ch << 11) | ((bits == 12) ? (m >> 1) : m);
    return (ch << 12) | m;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load(input int md, input int la, input int lb);
    for (int u = 0; u < 2; u++)
      for (int w = 0; w < 4; w++)
        wr(u * 4 + w, (rule(u, 4*w) << 24) | (rule(u, 4*w+1) << 16) |
                      (rule(u, 4*w+2) << 8) | rule(u, 4*w+3));
    wr(8, la - 1);
    wr(9, lb - 1);
    wr(10, md);
    len[0] = la; len[1] = lb; idx[0] = 0; idx[1] = 0;
    mode_m = md; alt_m = 0;
  endtask

  task automatic run_trig(input bit len_write, input bit poke);
    int srv, r [2], d [2], ew [2], n;
    bit dual;
    srv = (mode_m == 0) ? 1 : (mode_m == 1) ? 2 : (mode_m == 2) ? 3 : (alt_m ? 2 : 1);
    dual = (mode_m >= 2);
    for (int u = 0; u < 2; u++)
      if (srv[u]) begin
        r[u] = rule(u, idx[u]);
        idx[u] = (idx[u] + 1) % len[u];
      end
    if (mode_m == 3) alt_m = !alt_m;
    conv_m++; eof_m += (mode_m == 2) ? 2 : 1;
    @(negedge clk);
    trig = 1;
    if (len_write) begin cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = 32'(len[0] - 1); end
    @(negedge clk);
    trig = 0; cfg_we = 0;
    if (len_write) begin idx[0] = 0; alt_m = 0; end
    chk(req_valid == 2'(srv), (mode_m == 3) ? "R5 alternation" : "R4 units served", req_valid, srv);
    for (int u = 0; u < 2; u++)
      if (srv[u]) begin
        chk(req_chan[4*u +: 4] == 4'(r[u] >> 4) && req_res[2*u +: 2] == 2'(r[u] >> 2) &&
            req_atten[2*u +: 2] == 2'(r[u]),
            len_write ? "R12 old rule on write" : "R1 R2 R3 rule fields",
            {req_chan[4*u +: 4], req_res[2*u +: 2], req_atten[2*u +: 2]}, r[u]);
      end
    if (poke) begin
      trig = 1; @(negedge clk); trig = 0;
      if (srv == 1) begin res_valid = 2'b10; res_data = 24'hFFF000; @(negedge clk); res_valid = 0; end
      chk(out_valid == 0, "R11 stray result", out_valid, 0);
    end
    for (int k = 1; k >= 0; k--)
      if (srv[k]) begin
        nvec++;
        d[k] = (nvec * 1237 + k * 2911) & 12'hFFF;
        ew[k] = expw(k, r[k], dual, d[k]);
        res_valid = 2'(1 << k); res_data = 24'(d[k] << (12 * k));
        @(negedge clk);
        res_valid = 0;
      end
    n = 0;
    for (int u = 0; u < 2; u++)
      if (srv[u]) begin
        chk(out_valid && out_data == 16'(ew[u]),
            (mode_m == 2) ? "R9 R7 R8 both order" : dual ? "R7 R8 dual word" : "R6 R8 single word",
            out_data, ew[u]);
        if (n == 0) begin
          @(negedge clk);
          chk(out_valid && out_data == 16'(ew[u]), "R13 stall hold", out_data, ew[u]);
        end
        out_ready = 1; @(negedge clk); out_ready = 0;
        n++;
      end
    chk(out_valid == 0, "R9 word count", out_valid, 0);
    chk(conv_cnt == 16'(conv_m) && eof_cnt == 16'(eof_m), "R10 R11 counters",
        {conv_cnt, eof_cnt}, (conv_m << 16) | eof_m);
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid == 0 && out_valid == 0 && conv_cnt == 0 && eof_cnt == 0,
        "R10 reset state", {req_valid, out_valid, conv_cnt}, 0);
    len[0] = 1; len[1] = 1; idx[0] = 0; idx[1] = 0;
    for (int md = 0; md < 4; md++)
      for (int c = 0; c < 3; c++) begin
        int la, lb;
        la = (c == 0) ? 3 : (c == 1) ? 16 : 7;
        lb = (c == 0) ? 5 : (c == 1) ? 1 : 16;
        load(md, la, lb);
        for (int t = 0; t < 2 * 16 + 3; t++) run_trig(0, 0);
      end
    load(0, 4, 4);
    run_trig(0, 1);
    run_trig(0, 0);
    run_trig(1, 0);
    run_trig(0, 0);
    load(3, 2, 2);
    run_trig(0, 0);
    run_trig(0, 1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule